// File: doc/BRIEF.md
# Scanned Key Matrix Model With Paced Event Queue

This block stands in for a passive keyboard matrix that a scanning controller reads. The controller drives a vector of strobe (column) lines, and the block answers on its sense (row) lines. Each row holds a bitmap of the keys currently held down. A sense line is high whenever any held key in its row sits on an active strobe. The sense lines are computed combinationally, so the controller sees the answer in the same cycle it changes its strobes.

Key activity arrives as one-byte position codes. Each code carries a release flag, a row number and a column number. Codes are first written into a 16-entry circular queue. A free-running tick divider then drains the queue at one event per tick, which gives key changes a steady pace like a person typing. Row 7 has no matrix wiring: its five positions drive discrete side-button outputs directly, and output 4 can be built with inverted polarity.

A synchronous clear input releases every matrix key, empties the queue, clears the overflow flag and restarts the tick divider.

Top module: `keymatrix_emu`

## Requirements
- R1: Sense line r is high exactly when the row-r bitmap ANDed with the current strobe vector is nonzero. It follows strobe changes in the same cycle, without a clock edge.
- R2: An event code is laid out as bit 7 = release flag, bits 6:4 = row, bits 3:0 = column. Applying a code with bit 7 clear sets that key's bit, and applying one with bit 7 set clears it.
- R3: An event for row 7 with column c in 0..4 leaves the matrix untouched. Instead it drives side-button output c: 1 on press and 0 on release, before any polarity inversion.
- R4: When BTN4_INVERT is 1, side-button output 4 is driven with the opposite level to the one R3 gives. The other four outputs are never inverted.
- R5: Accepted events are applied in arrival order, at most one per tick. After reset or clear, the first tick applies an event on the TICK_DIV-th rising edge, and every later tick comes TICK_DIV edges after the one before.
- R6: A valid event that arrives while 16 events are waiting is dropped, and it sets the overflow output. Overflow stays set until reset or clear.
- R7: A code is ignored and never takes a queue slot if it names row 0..6 with a column above 10, or row 7 with a column above 4.
- R8: Clear releases every matrix key, discards all queued events, clears overflow and restarts the tick divider. It leaves the side-button outputs as they were.
- R9: After reset, every sense line is 0, overflow is 0, and side-button outputs 0..3 are 0. Output 4 is 0, or 1 when BTN4_INVERT is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event code present this cycle |
| ev_code | input | 8 | Release flag, row and column of the event |
| clear | input | 1 | Synchronous release-all and queue flush |
| strobe | input | NUM_COLS | Column strobes from the scanning controller |
| sense | output | NUM_ROWS | Row answers to the scanning controller |
| button | output | NUM_BTNS | Side-button levels |
| overflow | output | 1 | Sticky flag for an event dropped on a full queue |

## Verification
The assertions take for granted the following input conditions:
- rst_n is held low for at least one clock edge before activity starts.
- strobe may change at any time. Only sense depends on it, and it feeds no stored state.

The stimulus drives every input at falling edges, and it samples the combinational sense answer a fraction of a cycle after each strobe change. It waits at least two tick periods after pushing events before comparing against its own model of the bitmaps. The only exception is where the exact tick cycle is the thing under test; there, waits are counted from the edge on which clear was applied.

// File: rtl/keymatrix_emu.sv
`timescale 1ns/1ps
module keymatrix_emu #(
  parameter int NUM_ROWS    = 7,
  parameter int NUM_COLS    = 11,
  parameter int NUM_BTNS    = 5,
  parameter int QUEUE_DEPTH = 16,
  parameter int TICK_DIV    = 1562500,
  parameter bit BTN4_INVERT = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  logic [7:0]          ev_code,
  input  logic                clear,
  input  logic [NUM_COLS-1:0] strobe,
  output logic [NUM_ROWS-1:0] sense,
  output logic [NUM_BTNS-1:0] button,
  output logic                overflow
);
  localparam int QW = $clog2(QUEUE_DEPTH);
  localparam int CW = $clog2(QUEUE_DEPTH + 1);
  localparam int TW = $clog2(TICK_DIV);
  localparam logic [NUM_BTNS-1:0] INV_MASK =
    BTN4_INVERT ? (NUM_BTNS'(1) << 4) : '0;

  logic [TW-1:0] tick_cnt;
  logic          tick;
  assign tick = (tick_cnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                tick_cnt <= '0;
    else if (clear || tick)    tick_cnt <= '0;
    else                       tick_cnt <= tick_cnt + 1'b1;

  logic [2:0] in_row;
  logic [3:0] in_col;
  logic       in_ok;
  assign in_row = ev_code[6:4];
  assign in_col = ev_code[3:0];
  assign in_ok  = (int'(in_row) < NUM_ROWS) ? (int'(in_col) < NUM_COLS)
                : (int'(in_row) == NUM_ROWS) && (int'(in_col) < NUM_BTNS);

  logic [7:0]    q_mem [QUEUE_DEPTH];
  logic [QW-1:0] q_wr, q_rd;
  logic [CW-1:0] q_count;
  logic          q_full, push, pop;
  assign q_full = (q_count == CW'(QUEUE_DEPTH));
  assign push   = ev_valid && in_ok && !clear && !q_full;
  assign pop    = tick && (q_count != '0) && !clear;

  always_ff @(posedge clk)
    if (push) q_mem[q_wr] <= ev_code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q_wr <= '0; q_rd <= '0; q_count <= '0;
    end else if (clear) begin
      q_wr <= '0; q_rd <= '0; q_count <= '0;
    end else begin
      if (push) q_wr <= (q_wr == QW'(QUEUE_DEPTH - 1)) ? '0 : q_wr + 1'b1;
      if (pop)  q_rd <= (q_rd == QW'(QUEUE_DEPTH - 1)) ? '0 : q_rd + 1'b1;
      q_count <= q_count + CW'(push) - CW'(pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        overflow <= 1'b0;
    else if (clear)                    overflow <= 1'b0;
    else if (ev_valid && in_ok && q_full) overflow <= 1'b1;

  logic [7:0] head;
  logic       head_rel;
  logic [2:0] head_row;
  logic [3:0] head_col;
  assign head     = q_mem[q_rd];
  assign head_rel = head[7];
  assign head_row = head[6:4];
  assign head_col = head[3:0];

  logic [NUM_COLS-1:0] keys [NUM_ROWS];
  logic [NUM_BTNS-1:0] btn_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int r = 0; r < NUM_ROWS; r++) keys[r] <= '0;
    end else if (clear) begin
      for (int r = 0; r < NUM_ROWS; r++) keys[r] <= '0;
    end else if (pop && int'(head_row) < NUM_ROWS) begin
      keys[head_row][head_col] <= !head_rel;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) btn_q <= '0;
    else if (pop && int'(head_row) == NUM_ROWS) btn_q[head_col] <= !head_rel;

  assign button = btn_q ^ INV_MASK;

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_sense
    assign sense[g] = |(keys[g] & strobe);
  end
endmodule

module keymatrix_emu_chk #(
  parameter int NUM_ROWS    = 7,
  parameter int NUM_COLS    = 11,
  parameter int NUM_BTNS    = 5,
  parameter int QUEUE_DEPTH = 16,
  parameter int CW          = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clear,
  input logic                tick,
  input logic [NUM_COLS-1:0] strobe,
  input logic [NUM_ROWS-1:0] sense,
  input logic [NUM_BTNS-1:0] button,
  input logic                overflow,
  input logic [CW-1:0]       q_count
);
  a_r1_no_strobe_no_sense: assert property (@(posedge clk) disable iff (!rst_n)
    strobe == '0 |-> sense == '0);
  a_r8_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> sense == '0);
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clear |=> overflow);
  a_r6_overflow_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> int'($past(q_count)) == QUEUE_DEPTH);
  a_r5_one_pop_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> int'(q_count) + 1 >= int'($past(q_count)));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count) <= QUEUE_DEPTH);
  a_r3_buttons_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(button));
endmodule

bind keymatrix_emu keymatrix_emu_chk #(
  .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .NUM_BTNS(NUM_BTNS),
  .QUEUE_DEPTH(QUEUE_DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .tick(tick), .strobe(strobe),
  .sense(sense), .button(button), .overflow(overflow), .q_count(q_count)
);

// File: tb/test_keymatrix_emu.sv
`timescale 1ns/1ps
module test_keymatrix_emu;
  localparam int TD = 32;
  logic clk = 0, rst_n = 0, ev_valid = 0, clear = 0;
  logic [7:0] ev_code = '0;
  logic [10:0] strobe = '0;
  logic [6:0] sense;
  logic [4:0] button;
  logic overflow;
  int errs = 0, checks = 0;
  bit done = 0;
  logic [10:0] mdl [7];
  logic [4:0] mbtn = '0;

  always #5 clk = ~clk;

  keymatrix_emu #(.TICK_DIV(TD), .BTN4_INVERT(1'b1)) i_keymatrix_emu (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .clear(clear), .strobe(strobe), .sense(sense), .button(button),
    .overflow(overflow));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_sense(input logic [10:0] s);
    logic [6:0] e;
    for (int r = 0; r < 7; r++) e[r] = |(mdl[r] & s);
    return e;
  endfunction

  task automatic push(input int row, input int col, input bit rel);
    ev_valid = 1;
    ev_code = {rel, 3'(row), 4'(col)};
    @(negedge clk);
  endtask

  task automatic end_push();
    ev_valid = 0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (TD * n) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
  endtask

  task automatic check_onehot(input string req);
    for (int c = 0; c < 11; c++) begin
      strobe = 11'(1) << c; #1;
      check(req, 32'(sense), 32'(exp_sense(strobe)));
    end
    strobe = '0; #1;
    check(req, 32'(sense), 32'h0);
  endtask

  task automatic check_all(input string req);
    for (int s = 0; s < 2048; s++) begin
      strobe = 11'(s); #1;
      check(req, 32'(sense), 32'(exp_sense(strobe)));
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < 7; r++) mdl[r] = '0;
  endtask

  initial begin
    #1900000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state, R4 inverted output 4
    strobe = '1; #1;
    check("R9 sense", 32'(sense), 32'h0);
    check("R9 R4 button", 32'(button), 32'h10);
    check("R9 overflow", 32'(overflow), 32'h0);

    // R2 R1 every matrix key, one at a time
    for (int r = 0; r < 7; r++)
      for (int c = 0; c < 11; c++) begin
        @(negedge clk);
        push(r, c, 0); end_push(); mdl[r][c] = 1;
        wait_ticks(2);
        check_onehot("R2 press");
        push(r, c, 1); end_push(); mdl[r][c] = 0;
        wait_ticks(2);
        strobe = '1; #1;
        check("R2 release", 32'(sense), 32'h0);
      end

    // R3 R4 side buttons
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      push(7, c, 0); end_push(); mbtn[c] = 1;
      wait_ticks(2);
      check("R3 R4 button press", 32'(button), 32'(mbtn ^ 5'h10));
      strobe = '1; #1;
      check("R3 matrix untouched", 32'(sense), 32'h0);
      @(negedge clk);
      push(7, c, 1); end_push(); mbtn[c] = 0;
      wait_ticks(2);
      check("R3 R4 button release", 32'(button), 32'(mbtn ^ 5'h10));
    end

    // R1 multi-key patterns, full strobe sweep
    begin
      int n = 0;
      @(negedge clk);
      for (int k = 0; k < 77; k++)
        if (k % 3 == 0) begin
          push(k / 11, k % 11, 0); mdl[k / 11][k % 11] = 1; n++;
          if (n % 12 == 0) begin end_push(); wait_ticks(14); end
        end
      end_push(); wait_ticks(14);
      check_all("R1 pattern A");
      @(negedge clk);
      n = 0;
      for (int k = 0; k < 77; k++)
        if (k % 6 == 0) begin
          push(k / 11, k % 11, 1); mdl[k / 11][k % 11] = 0; n++;
          if (n % 12 == 0) begin end_push(); wait_ticks(14); end
        end
      end_push(); wait_ticks(14);
      check_all("R1 pattern B");
    end

    // R5 pacing and order, R7 ignored codes take no slot
    do_clear(); model_clear();
    push(0, 11, 0);
    push(7, 5, 0);
    push(2, 3, 0);
    push(2, 3, 1);
    push(4, 9, 0);
    end_push();
    repeat (TD - 6) @(negedge clk);
    strobe = 11'(1) << 3; #1;
    check("R5 no apply before first tick", 32'(sense), 32'h0);
    @(negedge clk); #1;
    check("R5 R7 first applied on tick", 32'(sense), 32'h04);
    check("R7 buttons untouched", 32'(button), 32'h10);
    repeat (TD - 1) @(negedge clk); #1;
    check("R5 second not yet", 32'(sense), 32'h04);
    @(negedge clk); #1;
    check("R5 order release", 32'(sense), 32'h0);
    repeat (TD) @(negedge clk);
    strobe = 11'(1) << 9; #1;
    check("R5 third", 32'(sense), 32'h10);
    mdl[4][9] = 1;
    check_onehot("R7 nothing else");

    // R6 overflow
    do_clear(); model_clear();
    for (int k = 0; k < 17; k++) begin
      push(k % 7, k / 7, 0);
      if (k < 16) mdl[k % 7][k / 7] = 1;
    end
    end_push();
    #1 check("R6 overflow set", 32'(overflow), 32'h1);
    wait_ticks(18);
    check_all("R6 dropped 17th");
    check("R6 overflow sticky", 32'(overflow), 32'h1);

    // R8 clear
    @(negedge clk);
    push(7, 2, 0); end_push(); mbtn[2] = 1;
    wait_ticks(2);
    push(6, 10, 0); push(5, 9, 0); push(3, 1, 0); end_push();
    do_clear(); model_clear();
    #1 check("R8 overflow cleared", 32'(overflow), 32'h0);
    check_onehot("R8 keys released");
    wait_ticks(4);
    check_onehot("R8 queue emptied");
    check("R8 buttons kept", 32'(button), 32'(mbtn ^ 5'h10));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule